// File: doc/BRIEF.md
# Receive Pause Flow Controller

This block decides when a full-duplex Ethernet MAC should ask its link partner to stop sending, judging by how much of its receive packet memory is still free. The memory is split into pages of 256 bytes. The block keeps a running count of free pages. The count drops by one for every page that an arriving frame claims. It rises by one for every page that the host hands back after it has consumed the data. With the default 32 pages (8 KB), the count ranges from 0 to 32.

Two programmable marks give the block hysteresis. When the free count falls to the low mark or below, the block enters a held state and raises a one-cycle request for a pause frame carrying the maximum quanta. While it stays held, it repeats that request each time a programmable refresh interval runs out, so the partner never resumes early. When the free count climbs to the high mark or above, the block leaves the held state and raises a single one-cycle request for a zero-quanta pause, which releases the partner at once. Typical settings are 15 for the low mark and 20 for the high mark.

Flow control only makes sense on a full-duplex link. Clearing the duplex input or setting the disable input drops the held state. While either is in effect, no request of any kind is raised.

Top module: `rx_pause_ctrl`

## Requirements
- R1: After reset the free count equals the page total (32 by default), the held flag is low, and both request outputs are low.
- R2: A cycle with only the allocate input high lowers the free count by one, and a cycle with only the release input high raises it by one; the new value appears on the count output after that clock edge. An allocate at a count of 0 and a release at the page total are ignored, so the count stays in place.
- R3: A cycle with both the allocate and release inputs high leaves the free count unchanged, including at 0 and at the page total.
- R4: When flow control is enabled, the block is not held, and the free count is at or below the low mark, then on the next edge the held flag rises and the max-quanta request is high for exactly that one cycle.
- R5: While the block is held and the free count is below the high mark, it stays held, even when the count has risen above the low mark.
- R6: While the block is held with flow control enabled and the free count at or above the high mark, the next edge clears the held flag and raises the zero-quanta request for one cycle.
- R7: While the block stays held, a max-quanta request is repeated exactly refresh-period cycles after the previous max-quanta request. A refresh period of 0 turns repetition off.
- R8: When the duplex input is low (half duplex) or the disable input is high, the next edge clears the held flag and raises no request of either kind. This includes leaving the held state, which then raises no zero-quanta request.
- R9: The max-quanta request and the zero-quanta request are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| alloc_i | input | 1 | One receive page claimed this cycle |
| free_i | input | 1 | One receive page returned this cycle |
| low_mark_i | input | 6 | Free-page level at or below which pausing starts |
| high_mark_i | input | 6 | Free-page level at or above which pausing stops |
| refresh_period_i | input | 16 | Cycles between repeated max-quanta requests; 0 turns repetition off |
| full_duplex_i | input | 1 | 1 = full-duplex link |
| fc_disable_i | input | 1 | 1 = flow control switched off |
| free_count_o | output | 6 | Current number of free pages |
| paused_o | output | 1 | Held (partner-paused) state |
| pause_req_o | output | 1 | One-cycle request for a max-quanta pause frame |
| resume_req_o | output | 1 | One-cycle request for a zero-quanta pause frame |

## Verification
The properties assume that the low mark is strictly below the high mark. They also assume that the refresh period is only changed while the block is not held; otherwise the repeat spacing checked for R7 has no fixed value. The stimulus sets the marks to 15 and 20 before reset is released and never changes them. It changes the refresh period only after a zero-quanta request has released the held state. It also waits for the internal reset release to complete before it claims or returns any page.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

  // Held / open state of the water-mark controller.
  typedef enum logic {
    FC_OPEN = 1'b0,
    FC_HOLD = 1'b1
  } fc_state_e;

  // Bits needed to count from 0 up to and including n.
  function automatic int count_bits(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rxp_rst_sync.sv
module rxp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/rxp_page_acct.sv
module rxp_page_acct #(
  parameter int PAGES = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             free,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(PAGES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  // Next-state: a simultaneous claim and return cancel out.
  always_comb begin
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    unique case ({alloc, free})
      2'b10: begin
        if (cnt_q != '0) begin
          cnt_n  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      2'b01: begin
        if (cnt_q != FULL) begin
          cnt_n  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: begin
        cnt_n  = cnt_q;
        cnt_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= FULL;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign count = cnt_q;

endmodule

// File: rtl/rxp_refresh.sv
module rxp_refresh #(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [REF_W-1:0] period,
  output logic             tick
);

  logic [REF_W-1:0] tmr_q;
  logic [REF_W-1:0] tmr_n;
  logic             tmr_en;

  always_comb begin
    tick   = run && (period != '0) && (tmr_q == period - 1'b1);
    tmr_n  = (!run || tick) ? '0 : tmr_q + 1'b1;
    tmr_en = run || (tmr_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_n;
  end

endmodule

// File: rtl/rxp_watermark.sv
module rxp_watermark
  import rxp_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] low_mark,
  input  logic [CNT_W-1:0] high_mark,
  input  logic             enable,
  input  logic             refresh_tick,
  output logic             paused,
  output logic             pause_req,
  output logic             resume_req
);

  fc_state_e state_q, state_n;
  logic      preq_q, preq_n;
  logic      rreq_q, rreq_n;

  always_comb begin
    state_n = state_q;
    preq_n  = 1'b0;
    rreq_n  = 1'b0;
    if (!enable) begin
      state_n = FC_OPEN;
    end else begin
      unique case (state_q)
        FC_OPEN: begin
          if (count <= low_mark) begin
            state_n = FC_HOLD;
            preq_n  = 1'b1;
          end
        end
        FC_HOLD: begin
          if (count >= high_mark) begin
            state_n = FC_OPEN;
            rreq_n  = 1'b1;
          end else if (refresh_tick) begin
            preq_n  = 1'b1;
          end
        end
        default: state_n = FC_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FC_OPEN;
      preq_q  <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      preq_q  <= preq_n;
      rreq_q  <= rreq_n;
    end
  end

  assign paused     = (state_q == FC_HOLD);
  assign pause_req  = preq_q;
  assign resume_req = rreq_q;

endmodule

// File: rtl/rx_pause_ctrl.sv
module rx_pause_ctrl
  import rxp_pkg::*;
#(
  parameter int PAGES = 32,
  parameter int REF_W = 16,
  localparam int CNT_W = count_bits(PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic             free_i,
  input  logic [CNT_W-1:0] low_mark_i,
  input  logic [CNT_W-1:0] high_mark_i,
  input  logic [REF_W-1:0] refresh_period_i,
  input  logic             full_duplex_i,
  input  logic             fc_disable_i,
  output logic [CNT_W-1:0] free_count_o,
  output logic             paused_o,
  output logic             pause_req_o,
  output logic             resume_req_o
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] count;
  logic             fc_enable;
  logic             held;
  logic             refresh_tick;

  assign fc_enable = full_duplex_i && !fc_disable_i;

  rxp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  rxp_page_acct #(.PAGES(PAGES), .CNT_W(CNT_W)) u_acct (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .alloc (alloc_i),
    .free  (free_i),
    .count (count)
  );

  rxp_refresh #(.REF_W(REF_W)) u_refresh (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (held),
    .period (refresh_period_i),
    .tick   (refresh_tick)
  );

  rxp_watermark #(.CNT_W(CNT_W)) u_wm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .count        (count),
    .low_mark     (low_mark_i),
    .high_mark    (high_mark_i),
    .enable       (fc_enable),
    .refresh_tick (refresh_tick),
    .paused       (held),
    .pause_req    (pause_req_o),
    .resume_req   (resume_req_o)
  );

  assign free_count_o = count;
  assign paused_o     = held;

endmodule

// File: rtl/rx_pause_ctrl_chk.sv
module rx_pause_ctrl_chk #(
  parameter int PAGES = 32,
  parameter int REF_W = 16,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_i,
  input logic             free_i,
  input logic [CNT_W-1:0] low_mark_i,
  input logic [CNT_W-1:0] high_mark_i,
  input logic [REF_W-1:0] refresh_period_i,
  input logic             full_duplex_i,
  input logic             fc_disable_i,
  input logic [CNT_W-1:0] free_count_o,
  input logic             paused_o,
  input logic             pause_req_o,
  input logic             resume_req_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(PAGES);

  logic en;
  assign en = full_duplex_i && !fc_disable_i;

  // R1
  a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    free_count_o <= FULL);

  // R2
  a_r2_alloc_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !free_i && free_count_o != '0) |=> free_count_o == $past(free_count_o) - 1'b1);

  a_r2_free_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (free_i && !alloc_i && free_count_o != FULL) |=> free_count_o == $past(free_count_o) + 1'b1);

  a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !free_i && free_count_o == '0) |=> free_count_o == '0);

  a_r2_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (free_i && !alloc_i && free_count_o == FULL) |=> free_count_o == FULL);

  // R3
  a_r3_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && free_i) |=> $stable(free_count_o));

  // R4
  a_r4_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (!paused_o && en && free_count_o <= low_mark_i) |=> (paused_o && pause_req_o));

  // R5
  a_r5_hysteresis: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_o && en && free_count_o < high_mark_i) |=> paused_o);

  // R6
  a_r6_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_o && en && free_count_o >= high_mark_i) |=> (!paused_o && resume_req_o));

  // R7: a repeat while held needs a nonzero refresh period
  a_r7_refresh_only_when_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req_o && $past(paused_o) && paused_o) |-> refresh_period_i != '0);

  // R8
  a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!paused_o && !pause_req_o && !resume_req_o));

  // R9
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pause_req_o && resume_req_o));

endmodule

bind rx_pause_ctrl rx_pause_ctrl_chk #(
  .PAGES(PAGES),
  .REF_W(REF_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_sync_n),
  .alloc_i          (alloc_i),
  .free_i           (free_i),
  .low_mark_i       (low_mark_i),
  .high_mark_i      (high_mark_i),
  .refresh_period_i (refresh_period_i),
  .full_duplex_i    (full_duplex_i),
  .fc_disable_i     (fc_disable_i),
  .free_count_o     (free_count_o),
  .paused_o         (paused_o),
  .pause_req_o      (pause_req_o),
  .resume_req_o     (resume_req_o)
);

// File: tb/tb_rx_pause_ctrl.sv
module tb_rx_pause_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int PAGES      = 32;
  localparam int REF_W      = 16;
  localparam int CNT_W      = 6;

  logic             clk;
  logic             rst_n;
  logic             alloc_i;
  logic             free_i;
  logic [CNT_W-1:0] low_mark_i;
  logic [CNT_W-1:0] high_mark_i;
  logic [REF_W-1:0] refresh_period_i;
  logic             full_duplex_i;
  logic             fc_disable_i;
  logic [CNT_W-1:0] free_count_o;
  logic             paused_o;
  logic             pause_req_o;
  logic             resume_req_o;

  rx_pause_ctrl #(.PAGES(PAGES), .REF_W(REF_W)) dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .alloc_i          (alloc_i),
    .free_i           (free_i),
    .low_mark_i       (low_mark_i),
    .high_mark_i      (high_mark_i),
    .refresh_period_i (refresh_period_i),
    .full_duplex_i    (full_duplex_i),
    .fc_disable_i     (fc_disable_i),
    .free_count_o     (free_count_o),
    .paused_o         (paused_o),
    .pause_req_o      (pause_req_o),
    .resume_req_o     (resume_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Scoreboard of expected requests
  int    q_cyc[$];
  bit    q_pause[$];
  string q_tag[$];

  // Expected state derived from the requirements
  int m_cnt;
  bit m_p;
  int m_tmr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input bit is_pause, input string tag);
    q_cyc.push_back(cyc + 1);
    q_pause.push_back(is_pause);
    q_tag.push_back(tag);
  endtask

  // Driver: applies one cycle of stimulus and predicts the outcome.
  task automatic step(input logic a, input logic f);
    bit en;
    int lo, hi, per;
    en  = full_duplex_i && !fc_disable_i;
    lo  = int'(low_mark_i);
    hi  = int'(high_mark_i);
    per = int'(refresh_period_i);
    alloc_i = a;
    free_i  = f;
    if (!en) begin
      m_p = 1'b0; m_tmr = 0;                    // R8
    end else if (!m_p) begin
      if (m_cnt <= lo) begin
        m_p = 1'b1; m_tmr = 0; push(1'b1, "R4");
      end
    end else if (m_cnt >= hi) begin
      m_p = 1'b0; m_tmr = 0; push(1'b0, "R6");
    end else if (per != 0 && m_tmr == per - 1) begin
      m_tmr = 0; push(1'b1, "R7");
    end else begin
      m_tmr++;
    end
    if (a && !f && m_cnt > 0)          m_cnt--;
    else if (f && !a && m_cnt < PAGES) m_cnt++;
    @(negedge clk);
    alloc_i = 1'b0;
    free_i  = 1'b0;
    chk(int'(free_count_o) == m_cnt, "R2/R3 free count", int'(free_count_o), m_cnt);
    chk(paused_o == m_p, "R5/R8 held flag", int'(paused_o), int'(m_p));
  endtask

  // Monitor: pops expected requests and compares them with observed pulses.
  always @(negedge clk) begin
    if (!done && rst_n) begin
      if (pause_req_o && resume_req_o) chk(1'b0, "R9 both requests high", 1, 0);
      while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        chk(1'b0, {q_tag[0], " missing request"}, 0, q_cyc[0]);
        void'(q_cyc.pop_front());
        void'(q_pause.pop_front());
        void'(q_tag.pop_front());
      end
      if (pause_req_o || resume_req_o) begin
        if (q_cyc.size() == 0) begin
          chk(1'b0, "R8 unexpected request", cyc, -1);
        end else begin
          chk(q_cyc[0] == cyc && q_pause[0] == pause_req_o,
              {q_tag[0], " request cycle/kind"}, cyc * 2 + int'(pause_req_o),
              q_cyc[0] * 2 + int'(q_pause[0]));
          void'(q_cyc.pop_front());
          void'(q_pause.pop_front());
          void'(q_tag.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n            = 1'b0;
    alloc_i          = 1'b0;
    free_i           = 1'b0;
    low_mark_i       = 6'd15;
    high_mark_i      = 6'd20;
    refresh_period_i = '0;
    full_duplex_i    = 1'b1;
    fc_disable_i     = 1'b0;
    m_cnt = PAGES;
    m_p   = 1'b0;
    m_tmr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(int'(free_count_o) == PAGES, "R1 free count", int'(free_count_o), PAGES);
    chk(!paused_o, "R1 held flag", int'(paused_o), 0);
    chk(!pause_req_o && !resume_req_o, "R1 requests", int'(pause_req_o | resume_req_o), 0);
    repeat (3) @(negedge clk);

    // R2 return at the page total is ignored
    step(1'b0, 1'b1);
    // R2 claim pages down to the low mark; R4 entry follows
    repeat (17) step(1'b1, 1'b0);
    repeat (4) step(1'b0, 1'b0);
    // R5 count rises above the low mark but stays held
    repeat (3) step(1'b0, 1'b1);
    chk(paused_o, "R5 held above low mark", int'(paused_o), 1);
    // R3 simultaneous claim and return
    step(1'b1, 1'b1);
    // R6 reach the high mark and release
    repeat (2) step(1'b0, 1'b1);
    repeat (3) step(1'b0, 1'b0);
    chk(!paused_o, "R6 released", int'(paused_o), 0);

    // R7 refresh every 5 cycles while held
    refresh_period_i = 16'd5;
    repeat (5) step(1'b1, 1'b0);
    repeat (14) step(1'b0, 1'b0);
    repeat (5) step(1'b0, 1'b1);
    repeat (2) step(1'b0, 1'b0);

    // R8 disabled: count falls below the low mark with no request
    fc_disable_i = 1'b1;
    repeat (10) step(1'b1, 1'b0);
    repeat (3) step(1'b0, 1'b0);
    chk(!paused_o, "R8 disabled not held", int'(paused_o), 0);
    fc_disable_i = 1'b0;
    repeat (3) step(1'b0, 1'b0);
    // R8 half duplex drops the held state silently
    full_duplex_i = 1'b0;
    repeat (3) step(1'b0, 1'b0);
    chk(!paused_o, "R8 half duplex not held", int'(paused_o), 0);

    // R2 floor at zero, R3 at zero
    repeat (12) step(1'b1, 1'b0);
    chk(free_count_o == '0, "R2 floor", int'(free_count_o), 0);
    step(1'b1, 1'b1);
    repeat (32) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    full_duplex_i = 1'b1;
    repeat (3) step(1'b0, 1'b0);

    chk(q_cyc.size() == 0, "R7 all expected requests seen", q_cyc.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule